// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a one-shot alarm timer. Software loads a number of seconds and then sets the run bit. While running, the block subtracts one from the remaining count on every one-second tick. When the count goes from 1 to 0, a sticky pending flag is set. That flag can drive an interrupt line and, through a separate gate, a wake line. Software can read the remaining count at any time. It clears the pending flag by writing a one to it.

The register interface is a simple single-cycle one. A write happens on a clock edge while `wr_en` is high. The read data is a combinational decode of `addr`. A second, week-based alarm is present only as three control and status registers. It has no time comparison, so it never becomes pending.

Word addresses (only bit 0 is used in the single-bit registers):
- 0: LOAD
- 1: REMAIN (read only)
- 2: RUN
- 3: IRQ_EN
- 4: STATUS
- 5: WAKE_EN
- 6: WK_RUN
- 7: WK_IRQ_EN
- 8: WK_STATUS

Top module: `cd_alarm`

## Requirements
- R1: After reset, every register reads 0 and `irq` and `wake` are low.
- R2: A write to LOAD (address 0) while RUN bit 0 is clear copies the value into REMAIN (address 1). LOAD reads back the last written value.
- R3: A write to LOAD while RUN bit 0 is set leaves REMAIN unchanged.
- R4: While RUN bit 0 is set and REMAIN is nonzero, each clock with `tick` high lowers REMAIN by exactly one. Clocks without `tick` leave it unchanged.
- R5: While RUN bit 0 is clear, `tick` leaves REMAIN unchanged.
- R6: On the tick that takes REMAIN from 1 to 0, STATUS bit 0 becomes 1. After that, REMAIN stays 0 and STATUS bit 0 stays 1 until software clears it.
- R7: Writing 1 to STATUS bit 0 clears it, and writing 0 has no effect. If the expiry tick and the clear write fall in the same cycle, the flag ends up set.
- R8: `irq` is high exactly when STATUS bit 0 and IRQ_EN bit 0 (address 3) are both 1.
- R9: `wake` is high exactly when STATUS bit 0 and WAKE_EN bit 0 (address 5) are both 1, whatever the value of IRQ_EN.
- R10: Loading 0 and then setting RUN never sets STATUS bit 0, however many ticks arrive.
- R11: WK_RUN (address 6) and WK_IRQ_EN (address 7) hold their written bit 0. WK_STATUS (address 8) reads 0 and never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| irq | output | 1 | Alarm interrupt |
| wake | output | 1 | Alarm wake request |

## Verification
The hardest case to reach is the expiry tick landing in the same cycle as a write that clears the status. The stimulus loads a count of 1 and sets RUN. It then drives `tick` and the STATUS clear write in one cycle and checks that the flag remains set. A second hard case is a load that arrives while the timer is running. The bench writes a new count mid-countdown and confirms that the next ticks continue from the old value.

// File: rtl/cd_alarm.sv
module cd_alarm #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              irq,
  output logic              wake
);
  localparam logic [ADDR_W-1:0] A_LOAD = 0, A_REM = 1, A_RUN = 2, A_IEN = 3,
    A_STAT = 4, A_WAKE = 5, A_WRUN = 6, A_WIEN = 7, A_WSTAT = 8;

  logic [CNT_W-1:0] load_q, remain_q;
  logic run_q, ien_q, pend_q, wken_q, wrun_q, wien_q, wpend_q;

  wire wr_load = wr_en && addr == A_LOAD;
  wire clr_pnd = wr_en && addr == A_STAT && wdata[0];
  wire step    = run_q && tick && remain_q != '0;
  wire expire  = step && remain_q == CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0; remain_q <= '0;
      run_q <= 1'b0; ien_q <= 1'b0; pend_q <= 1'b0; wken_q <= 1'b0;
      wrun_q <= 1'b0; wien_q <= 1'b0; wpend_q <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata;
      if (wr_load && !run_q) remain_q <= wdata;
      else if (step)         remain_q <= remain_q - 1'b1;
      if (expire)       pend_q <= 1'b1;
      else if (clr_pnd) pend_q <= 1'b0;
      if (wr_en && addr == A_WSTAT && wdata[0]) wpend_q <= 1'b0;
      if (wr_en) begin
        case (addr)
          A_RUN:  run_q  <= wdata[0];
          A_IEN:  ien_q  <= wdata[0];
          A_WAKE: wken_q <= wdata[0];
          A_WRUN: wrun_q <= wdata[0];
          A_WIEN: wien_q <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LOAD:  rdata = load_q;
      A_REM:   rdata = remain_q;
      A_RUN:   rdata[0] = run_q;
      A_IEN:   rdata[0] = ien_q;
      A_STAT:  rdata[0] = pend_q;
      A_WAKE:  rdata[0] = wken_q;
      A_WRUN:  rdata[0] = wrun_q;
      A_WIEN:  rdata[0] = wien_q;
      A_WSTAT: rdata[0] = wpend_q;
      default: rdata = '0;
    endcase
  end

  assign irq  = (pend_q && ien_q) || (wpend_q && wien_q);
  assign wake = pend_q && wken_q;

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && remain_q != '0) |=> remain_q == $past(remain_q) - 1'b1);
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_load) |=> $stable(remain_q));
  a_r6_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick && remain_q == CNT_W'(1)) |=> (pend_q && remain_q == '0));
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_pnd) |=> pend_q);
  a_r10_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (remain_q == '0 && !wr_load) |=> remain_q == '0);
  a_r11_week_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wpend_q);
endmodule

// File: tb/cd_alarm_tb_top.sv
module cd_alarm_tb_top;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq, wake;
  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cd_alarm dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .wake(wake));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic t = 1'b0);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; tick = t;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 9; a++) begin rd(a[3:0], d); chk("R1 reg", d, 0); end
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);
  endtask

  task automatic t_load_count;
    logic [31:0] d;
    wr(0, 5); rd(1, d); chk("R2 remain", d, 5); rd(0, d); chk("R2 load rb", d, 5);
    ticks(2); rd(1, d); chk("R5 frozen", d, 5);
    wr(2, 1); ticks(2); rd(1, d); chk("R4 two ticks", d, 3);
    repeat (4) @(negedge clk); rd(1, d); chk("R4 no tick", d, 3);
    wr(0, 100); rd(1, d); chk("R3 load while run", d, 3);
    rd(0, d); chk("R2 load rb", d, 100);
    wr(2, 0); ticks(1); rd(1, d); chk("R5 disabled", d, 3);
    wr(2, 1); ticks(2); rd(1, d); chk("R6 before", d, 1); rd(4, d); chk("R6 not yet", d, 0);
    ticks(1); rd(1, d); chk("R6 zero", d, 0); rd(4, d); chk("R6 pend", d, 1);
    ticks(3); rd(1, d); chk("R6 hold0", d, 0); rd(4, d); chk("R6 sticky", d, 1);
  endtask

  task automatic t_outputs;
    logic [31:0] d;
    chk("R8 irq off", irq, 0); chk("R9 wake off", wake, 0);
    wr(5, 1); chk("R9 wake on", wake, 1); chk("R8 irq still off", irq, 0);
    wr(3, 1); chk("R8 irq on", irq, 1);
    wr(4, 0); rd(4, d); chk("R7 write0", d, 1);
    wr(4, 1); rd(4, d); chk("R7 w1c", d, 0);
    chk("R8 irq cleared", irq, 0); chk("R9 wake cleared", wake, 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(2, 0); wr(0, 1); wr(2, 1);
    wr(4, 1, 1'b1); rd(4, d); chk("R7 set wins", d, 1); chk("R8 irq race", irq, 1);
    wr(4, 1); rd(4, d); chk("R7 clear after", d, 0);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    wr(2, 0); wr(0, 0); wr(2, 1); ticks(4);
    rd(4, d); chk("R10 no pend", d, 0); rd(1, d); chk("R10 remain", d, 0);
  endtask

  task automatic t_week;
    logic [31:0] d;
    wr(6, 1); wr(7, 1); wr(3, 0);
    rd(6, d); chk("R11 wrun", d, 1); rd(7, d); chk("R11 wien", d, 1);
    ticks(3); rd(8, d); chk("R11 wstat", d, 0); chk("R11 irq", irq, 0);
  endtask

  initial begin
    fork
      begin
        #1; t_reset();
        repeat (2) @(negedge clk); rst_n = 1'b1;
        t_load_count(); t_outputs(); t_race(); t_zero(); t_week();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule